// File: doc/BRIEF.md
# Frame-Synchronized Line-Rate Boost Clock

This block produces a step-up clock for a charge pump, running at a power-of-two fraction of the display line rate. It receives a single-cycle pulse once per display line and counts lines through a frame. A frame is built from three regions, each sized by an input setting: the back porch, the active display area and the front porch. The active region is programmed in steps of four lines.

The step-up clock is a line-rate divider. A 3-bit code selects a period of 2^code lines. The output is high for the first half of each period and low for the second half. The divider phase restarts on the first back-porch line of every frame. This keeps the clock aligned frame after frame, so the pump does not beat against the picture. When a frame is not a whole number of periods long, the last partial period is cut short. Settings are captured at reset and at each frame boundary, so a mid-frame change never gives a frame of mixed length.

Top module: `frame_boost_clk`

## Requirements
- R1: While reset is asserted, at the next clock edge the line number is 0, the step-up clock is high and the frame-start flag is low.
- R2: The line number rises by one on each clock edge at which the line pulse is high, unless the frame wraps. Without a line pulse, the line number and the step-up clock keep their values.
- R3: The frame length is back-porch + 4 × (display setting + 1) + front-porch lines. On the line pulse that ends line (length − 1), the line number returns to 0. Line 0 is the first back-porch line. Example: porches of 8 with display setting 0x6B give lines 0x000 to 0x1BF.
- R4: The frame-start flag is high for exactly one clock cycle: the cycle in which the line number has just returned to 0 by a wrap. It is low at every other time.
- R5: For a code c in 1..7, the step-up clock has a period of 2^c lines. Counting lines from the frame start, the output is high while bit (c−1) of the line count is 0 and low while that bit is 1.
- R6: Code 0 behaves exactly like code 1, giving a two-line period.
- R7: The divider phase restarts when the frame wraps. The step-up clock is high on line 0 of every frame, which cuts any partial period short.
- R8: The porch, display and code inputs are sampled during reset and on the wrapping line pulse only. Changes at any other time have no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per display line |
| bp_lines | input | 8 | Back-porch length in lines |
| fp_lines | input | 8 | Front-porch length in lines |
| disp_set | input | 7 | Active lines = 4 × (disp_set + 1) |
| div_code | input | 3 | Step-up period = 2^div_code lines (0 acts as 1) |
| boost_clk | output | 1 | Step-up clock |
| line_num | output | 10 | Current line within the frame |
| frame_start | output | 1 | One-cycle pulse when the line count returns to 0 |

## Verification
The bench targets frames that are not a multiple of the divided period. A divider that is not re-phased at the wrap would drift, and its clock would start low in some frames. It also changes settings in the middle of a frame. A design that does not hold the settings would wrap early or late, or switch period partway through a frame. Three further cases are checked: code 0, where a design that indexes bit −1 would produce a stuck or wrong clock; the largest period (longer than a short frame); and the full 448-line frame, which exposes off-by-one errors at the 0x1BF wrap and in the ×4 display scaling.

// File: rtl/frame_boost_pkg.sv
// Shared defaults for the line-rate boost clock block.
// Assumes: all widths below are used as parameter defaults by the top.
package frame_boost_pkg;
    localparam int unsigned PORCH_W_DEF   = 8;  // porch setting width
    localparam int unsigned DISP_W_DEF    = 7;  // display setting width
    localparam int unsigned CODE_W_DEF    = 3;  // divide code width
    localparam int unsigned DISP_STEP_LOG = 2;  // display lines per step = 4
endpackage

// File: rtl/blc_cfg_shadow.sv
// Holds the frame settings stable for a whole frame and derives the frame
// length from them. Loads during reset and on the frame wrap pulse.
// Assumes: load is a single-cycle strobe aligned with a line pulse.
module blc_cfg_shadow #(
    parameter int unsigned PORCH_W  = 8,
    parameter int unsigned DISP_W   = 7,
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned STEP_LOG = 2,
    parameter int unsigned LINE_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PORCH_W-1:0] bp_in,
    input  logic [PORCH_W-1:0] fp_in,
    input  logic [DISP_W-1:0]  disp_in,
    input  logic [CODE_W-1:0]  code_in,
    output logic [LINE_W-1:0]  frame_len,
    output logic [CODE_W-1:0]  code_next
);
    logic [PORCH_W-1:0] bp_q;
    logic [PORCH_W-1:0] fp_q;
    logic [DISP_W-1:0]  disp_q;
    logic [CODE_W-1:0]  code_q;

    // Capture settings at reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            bp_q   <= bp_in;
            fp_q   <= fp_in;
            disp_q <= disp_in;
            code_q <= code_in;
        end
    end

    // Frame length from the held settings.
    always_comb begin
        frame_len = LINE_W'(bp_q) + LINE_W'(fp_q)
                  + ((LINE_W'(disp_q) + LINE_W'(1)) << STEP_LOG);
    end

    // Code that will be in force after this edge.
    always_comb begin
        code_next = load ? code_in : code_q;
    end
endmodule

// File: rtl/blc_line_counter.sv
// Counts display lines within a frame and flags the wrap back to line 0.
// Assumes: frame_len is at least 1 and stays constant between wraps.
module blc_line_counter #(
    parameter int unsigned LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] frame_len,
    output logic [LINE_W-1:0] line_num,
    output logic              wrap,
    output logic              frame_start
);
    logic [LINE_W-1:0] line_q;
    logic              at_last;

    // Detect the final line of the frame (>= guards any shrink).
    always_comb begin
        at_last = (line_q >= (frame_len - LINE_W'(1)));
        wrap    = line_tick && at_last;
    end

    // Advance the line count on each line pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (line_tick) begin
            line_q <= at_last ? '0 : line_q + LINE_W'(1);
        end
    end

    // One-cycle flag marking the return to line 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
        end else begin
            frame_start <= wrap;
        end
    end

    assign line_num = line_q;
endmodule

// File: rtl/blc_phase_div.sv
// Divides the line rate by 2^code using a line-phase counter that restarts
// at each frame wrap. Output is high in the first half of each period.
// Assumes: code 0 is clamped to code 1 (half a line cannot be expressed).
module blc_phase_div #(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              wrap,
    input  logic [CODE_W-1:0] code_next,
    output logic              boost_clk
);
    localparam int unsigned NCODE   = 1 << CODE_W;
    localparam int unsigned PHASE_W = NCODE - 1;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_nxt;
    logic [NCODE-1:0]   lane;
    logic               boost_q;

    // Next phase: restart at the wrap, else step by one line.
    always_comb begin
        phase_nxt = wrap ? '0 : phase_q + PHASE_W'(1);
    end

    // One candidate output per code; code 0 shares the code 1 tap.
    generate
        for (genvar k = 0; k < NCODE; k++) begin : g_lane
            if (k == 0) begin : g_clamp
                assign lane[k] = ~phase_nxt[0];
            end else begin : g_tap
                assign lane[k] = ~phase_nxt[k-1];
            end
        end
    endgenerate

    // Phase counter advances only on line pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (line_tick) begin
            phase_q <= phase_nxt;
        end
    end

    // Registered output so the pump clock is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost_q <= 1'b1;
        end else if (line_tick) begin
            boost_q <= lane[code_next];
        end
    end

    assign boost_clk = boost_q;
endmodule

// File: rtl/frame_boost_clk.sv
// Top of the frame-synchronized line-rate boost clock. Ties the settings
// holder, the frame line counter and the line-phase divider together.
// Assumes: line_tick is a single-cycle pulse, at most one per line.
module frame_boost_clk
    import frame_boost_pkg::*;
#(
    parameter int unsigned PORCH_W  = PORCH_W_DEF,
    parameter int unsigned DISP_W   = DISP_W_DEF,
    parameter int unsigned CODE_W   = CODE_W_DEF,
    parameter int unsigned STEP_LOG = DISP_STEP_LOG,
    parameter int unsigned LINE_W   = $clog2((2 << PORCH_W) + ((1 << DISP_W) << STEP_LOG))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_tick,
    input  logic [PORCH_W-1:0] bp_lines,
    input  logic [PORCH_W-1:0] fp_lines,
    input  logic [DISP_W-1:0]  disp_set,
    input  logic [CODE_W-1:0]  div_code,
    output logic               boost_clk,
    output logic [LINE_W-1:0]  line_num,
    output logic               frame_start
);
    logic [LINE_W-1:0] frame_len;
    logic [CODE_W-1:0] code_next;
    logic              wrap;

    blc_cfg_shadow #(
        .PORCH_W (PORCH_W),
        .DISP_W  (DISP_W),
        .CODE_W  (CODE_W),
        .STEP_LOG(STEP_LOG),
        .LINE_W  (LINE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wrap),
        .bp_in    (bp_lines),
        .fp_in    (fp_lines),
        .disp_in  (disp_set),
        .code_in  (div_code),
        .frame_len(frame_len),
        .code_next(code_next)
    );

    blc_line_counter #(
        .LINE_W(LINE_W)
    ) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .frame_len  (frame_len),
        .line_num   (line_num),
        .wrap       (wrap),
        .frame_start(frame_start)
    );

    blc_phase_div #(
        .CODE_W(CODE_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick),
        .wrap     (wrap),
        .code_next(code_next),
        .boost_clk(boost_clk)
    );
endmodule

// File: rtl/frame_boost_clk_chk.sv
// Port-level temporal checks for frame_boost_clk, attached by bind.
module frame_boost_clk_chk #(
    parameter int unsigned LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              boost_clk,
    input logic [LINE_W-1:0] line_num,
    input logic              frame_start
);
    // R1: reset state one edge after reset is seen
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (line_num == '0) && boost_clk && !frame_start);

    // R2: a line pulse either steps the count or wraps it to zero
    a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |=> (line_num == $past(line_num) + LINE_W'(1)) || (line_num == '0));

    // R2: without a line pulse nothing moves
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_num) && $stable(boost_clk));

    // R4: frame start only follows a line pulse and marks line 0
    a_r4_start_line0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_num == '0) && $past(line_tick));

    // R4: the flag lasts a single cycle
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R7: the step-up clock is high at each frame start
    a_r7_resync_high: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> boost_clk);
endmodule

bind frame_boost_clk frame_boost_clk_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick),
    .boost_clk  (boost_clk),
    .line_num   (line_num),
    .frame_start(frame_start)
);

// File: tb/tb_frame_boost_clk.sv
module tb_frame_boost_clk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic [7:0] bp_lines = 8'd2;
    logic [7:0] fp_lines = 8'd1;
    logic [6:0] disp_set = 7'd0;
    logic [2:0] div_code = 3'd1;
    logic       boost_clk;
    logic [9:0] line_num;
    logic       frame_start;

    always #4 clk = ~clk;  // 125 MHz

    frame_boost_clk dut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .bp_lines(bp_lines), .fp_lines(fp_lines), .disp_set(disp_set),
        .div_code(div_code), .boost_clk(boost_clk), .line_num(line_num),
        .frame_start(frame_start)
    );

    int    checks = 0;
    int    errors = 0;
    string tag_ovr = "";
    int    m_line, m_phase, s_bp, s_fp, s_disp, s_code;
    bit    m_fs;
    bit    done = 0;

    function automatic int flen(int bp, int fp, int disp);
        return bp + 4 * (disp + 1) + fp;
    endfunction

    function automatic int exp_boost(int ph, int code);
        int c = (code < 1) ? 1 : code;  // R6 clamp
        return (((ph >> (c - 1)) & 1) == 0) ? 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(string tl, string tb);
        string l = (tag_ovr != "") ? tag_ovr : tl;
        string b = (tag_ovr != "") ? tag_ovr : tb;
        chk(l, "line_num", int'(line_num), m_line);
        chk(b, "boost_clk", int'(boost_clk), exp_boost(m_phase, s_code));
        chk("R4", "frame_start", int'(frame_start), int'(m_fs));
    endtask

    task automatic load_shadow();
        s_bp = bp_lines; s_fp = fp_lines; s_disp = disp_set; s_code = div_code;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        line_tick = 1'b0;
        repeat (2) @(negedge clk);
        load_shadow();
        m_line = 0; m_phase = 0; m_fs = 0;
        check_outputs("R1", "R1");
        rst_n = 1'b1;
    endtask

    task automatic tick(int gap);
        bit wrap;
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
        wrap = (m_line >= flen(s_bp, s_fp, s_disp) - 1);
        if (wrap) begin
            m_line = 0; m_phase = 0; load_shadow();
            tag_ovr = "";
        end else begin
            m_line++; m_phase = (m_phase + 1) & 127;
        end
        m_fs = wrap;
        check_outputs(wrap ? "R3" : "R2",
                      wrap ? "R7" : ((s_code == 0) ? "R6" : "R5"));
        m_fs = 0;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            check_outputs("R2", "R2");
        end
    endtask

    task automatic run_frames(int n, int gap);
        for (int f = 0; f < n; f++) begin
            tick(gap);
            while (m_line != 0) tick(gap);
        end
    endtask

    initial begin
        #1_200_000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0711));
        // R1: reset with a 7-line frame, code 1
        do_reset();
        run_frames(3, 1);
        // R8: change settings mid-frame; model keeps old values until wrap
        tick(0); tick(0); tick(0);
        div_code = 3'd2; bp_lines = 8'd5; tag_ovr = "R8";
        run_frames(1, 1);
        run_frames(2, 0);
        // R6: code 0 acts as code 1
        div_code = 3'd0; run_frames(1, 0);
        run_frames(2, 1);
        // R3: 448-line frame, code 4; check last line before wrap
        bp_lines = 8'h08; fp_lines = 8'h08; disp_set = 7'h6B; div_code = 3'd4;
        run_frames(1, 0);
        while (m_line != 447) tick(0);
        chk("R3", "last line", int'(line_num), 'h1BF);
        tick(1);
        chk("R3", "wrap to zero", int'(line_num), 0);
        // R7: code 7, period 128 does not divide 448
        div_code = 3'd7;
        run_frames(2, 0);
        // random frames with mid-frame changes
        for (int r = 0; r < 40; r++) begin
            bp_lines = 8'($urandom_range(0, 12));
            fp_lines = 8'($urandom_range(0, 12));
            disp_set = 7'($urandom_range(0, 5));
            div_code = 3'($urandom_range(0, 7));
            tick($urandom_range(0, 2));
            if (m_line != 0 && $urandom_range(0, 1) == 1) begin
                div_code = 3'($urandom_range(0, 7));
                fp_lines = 8'($urandom_range(0, 12));
                tag_ovr = "R8";
            end
            while (m_line != 0) tick($urandom_range(0, 2));
        end
        // R1: reset in mid-frame
        tick(0); tick(0); tick(0);
        do_reset();
        tick(0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule